// File: doc/BRIEF.md
# Serial Bit-Balance Threshold Detector

This block watches a serial bit stream, one bit per accepted clock cycle, and tracks how far the count of zeros has drifted from the count of ones since the last reset. While neither value is ahead of the other by more than one, the 2-bit verdict stays at 00. The first time one polarity gets two ahead, the verdict locks to a code naming that polarity. It keeps that code until the next reset, whatever arrives afterwards.

An accompanying strobe marks the cycles that carry a real bit. Cycles without the strobe are ignored. The verdict is combinational in the current bit. On the cycle that brings in the deciding bit, the verdict already shows the locked code, before the clock edge that stores it.

Top module: `bitbal_detect`

## Requirements
- R1: With `rst` high at a rising edge, the block returns to the balanced state. In the cycle that follows, `verdict` is 2'b00.
- R2: While the zero-minus-one difference of accepted bits stays in the range -1 to +1 and no lock has happened, `verdict` is 2'b00. `verdict` never takes the value 2'b11.
- R3: When an accepted bit makes zeros lead ones by two, `verdict` becomes 2'b10 (bit 1 means zeros won) in that same cycle, while the bit is still at the input.
- R4: When an accepted bit makes ones lead zeros by two, `verdict` becomes 2'b01 (bit 0 means ones won) in that same cycle.
- R5: Once `verdict` is 2'b10 or 2'b01, it keeps that value on every later cycle until reset, whatever the values of `in_bit` and `in_valid`.
- R6: A cycle with `in_valid` low does not change the running difference. In such a cycle `verdict` depends only on the stored state.
- R7: A reset in the middle of a stream clears both the running difference and any lock. Counting starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial data bit |
| verdict | output | 2 | 00 undecided, 10 zeros won, 01 ones won |

## Verification
Every verdict is due in the same cycle as the bit that causes it, because one stage of combinational logic lies between the input pins and `verdict`. The stored state changes only at the following rising edge. The bench therefore drives each bit shortly after a falling edge and samples `verdict` 1 ns later, before the rising edge. It updates its own zero and one counts only after that edge. Reset is checked in the first cycle after `rst` drops, with no valid bit present.

// File: rtl/bitbal_pkg.sv
package bitbal_pkg;

   // state encoding: bit 2 marks an absorbing (decided) state
   typedef enum logic [2:0] {
      ST_EVEN  = 3'd0,   // zeros == ones
      ST_ZUP   = 3'd1,   // zeros lead by one
      ST_OUP   = 3'd2,   // ones lead by one
      ST_ZWON  = 3'd4,   // zeros reached a lead of two
      ST_OWON  = 3'd5    // ones reached a lead of two
   } bb_state_e;

   localparam int unsigned BB_STATE_W = 3;
   localparam int unsigned BB_VERD_W  = 2;

   localparam logic [BB_VERD_W-1:0] VERD_OPEN  = 2'b00;
   localparam logic [BB_VERD_W-1:0] VERD_ZEROS = 2'b10;
   localparam logic [BB_VERD_W-1:0] VERD_ONES  = 2'b01;

endpackage

// File: rtl/bitbal_step.sv
module bitbal_step
   import bitbal_pkg::*;
(
   input  bb_state_e                cur_st,
   input  logic                     take,
   input  logic                     bit_val,
   output bb_state_e                nxt_st,
   output logic [BB_VERD_W-1:0]     verd
);

   // next state of the balance walk
   always_comb begin
      nxt_st = cur_st;
      unique case (cur_st)
         ST_EVEN: if (take) nxt_st = bit_val ? ST_OUP  : ST_ZUP;
         ST_ZUP:  if (take) nxt_st = bit_val ? ST_EVEN : ST_ZWON;
         ST_OUP:  if (take) nxt_st = bit_val ? ST_OWON : ST_EVEN;
         ST_ZWON: nxt_st = ST_ZWON;
         ST_OWON: nxt_st = ST_OWON;
         default: nxt_st = ST_EVEN;
      endcase
   end

   // Mealy verdict: decode the state about to be stored, so the deciding
   // bit shows up in its own cycle; absorbing states map onto themselves
   always_comb begin
      unique case (nxt_st)
         ST_ZWON: verd = VERD_ZEROS;
         ST_OWON: verd = VERD_ONES;
         default: verd = VERD_OPEN;
      endcase
   end

endmodule

// File: rtl/bitbal_state.sv
module bitbal_state
   import bitbal_pkg::*;
#(
   parameter bb_state_e RESET_ST = ST_EVEN
)(
   input  logic      clk,
   input  logic      rst,
   input  bb_state_e d,
   output bb_state_e q
);

   initial begin
      assert (RESET_ST == ST_EVEN)
         else $error("bitbal_state: reset state must be the balanced state");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_ST;
      else     q <= d;
   end

endmodule

// File: rtl/bitbal_detect.sv
module bitbal_detect
   import bitbal_pkg::*;
#(
   parameter int unsigned VERDICT_W = 2
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic                 in_bit,
   output logic [VERDICT_W-1:0] verdict
);

   localparam int unsigned ST_W = $bits(bb_state_e);

   initial begin
      assert (VERDICT_W == BB_VERD_W)
         else $error("bitbal_detect: VERDICT_W must be %0d", BB_VERD_W);
      assert (ST_W == BB_STATE_W)
         else $error("bitbal_detect: state width mismatch");
   end

   bb_state_e                 state_q;
   bb_state_e                 state_d;
   logic [BB_VERD_W-1:0]      verd_c;

   bitbal_step step_i (
      .cur_st  (state_q),
      .take    (in_valid),
      .bit_val (in_bit),
      .nxt_st  (state_d),
      .verd    (verd_c)
   );

   bitbal_state #(.RESET_ST(ST_EVEN)) reg_i (
      .clk (clk),
      .rst (rst),
      .d   (state_d),
      .q   (state_q)
   );

   assign verdict = verd_c;

endmodule

// File: rtl/bitbal_detect_chk.sv
module bitbal_detect_chk (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_bit,
   input logic [1:0] verdict,
   input logic [2:0] state_q
);

   // R1
   reset_open_chk: assert property (@(posedge clk)
      rst |=> (verdict == 2'b00));

   // R2
   verdict_legal_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(verdict));

   // R3
   zero_win_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(verdict[1]) |-> (in_valid && !in_bit));

   // R4
   one_win_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(verdict[0]) |-> (in_valid && in_bit));

   // R5
   lock_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (verdict != 2'b00) |=> $stable(verdict));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(state_q));

endmodule

bind bitbal_detect bitbal_detect_chk chk_i (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_bit   (in_bit),
   .verdict  (verdict),
   .state_q  (state_q)
);

// File: tb/bitbal_detect_tb_top.sv
`timescale 1ns/1ps
module bitbal_detect_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_bit = 1'b0;
   logic [1:0] verdict;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   // reference model
   int         zc = 0;
   int         oc = 0;
   logic [1:0] lock_m = 2'b00;

   always #5 clk = ~clk;

   bitbal_detect dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .verdict  (verdict)
   );

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: verdict=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive after falling edge, check before rising edge, commit model
   task automatic step(input logic v, input logic b, input string req);
      logic [1:0] exp;
      int tz, tn;
      @(negedge clk);
      in_valid = v;
      in_bit   = b;
      tz = zc + ((v && !b) ? 1 : 0);
      tn = oc + ((v &&  b) ? 1 : 0);
      if (lock_m != 2'b00)  exp = lock_m;
      else if (tz == tn + 2) exp = 2'b10;
      else if (tn == tz + 2) exp = 2'b01;
      else                   exp = 2'b00;
      #1;
      check(req, verdict, exp);
      @(posedge clk);
      zc = tz;
      oc = tn;
      lock_m = exp;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      zc = 0; oc = 0; lock_m = 2'b00;
      #1;
      check("R1", verdict, 2'b00);
   endtask

   task automatic t_zero_pair();
      do_reset();
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, "R3");
      check("R3", lock_m, 2'b10);
   endtask

   task automatic t_one_pair();
      do_reset();
      step(1'b1, 1'b1, "R2");
      step(1'b1, 1'b1, "R4");
      check("R4", lock_m, 2'b01);
   endtask

   task automatic t_alternate();
      do_reset();
      for (int i = 0; i < 24; i++) step(1'b1, i[0], "R2");
      for (int i = 0; i < 24; i++) step(1'b1, ~i[0], "R2");
      check("R2", lock_m, 2'b00);
   endtask

   task automatic t_idle_gap();
      do_reset();
      step(1'b1, 1'b0, "R6");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R6");
      check("R6", verdict, 2'b00);
      step(1'b1, 1'b1, "R6");
      step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "R6");
      step(1'b1, 1'b1, "R4");
   endtask

   task automatic t_lock_hold();
      do_reset();
      step(1'b1, 1'b1, "R4");
      step(1'b1, 1'b1, "R4");
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R5");
      step(1'b0, 1'b0, "R5");
      check("R5", verdict, 2'b01);
      do_reset();
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, "R3");
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R5");
      check("R5", verdict, 2'b10);
   endtask

   task automatic t_mid_reset();
      do_reset();
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b0, "R7");
      do_reset();
      check("R7", verdict, 2'b00);
      step(1'b1, 1'b1, "R7");
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b1, "R7");
      step(1'b1, 1'b1, "R7");
      check("R7", lock_m, 2'b01);
      do_reset();
      step(1'b1, 1'b1, "R7");
      do_reset();
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b1, "R7");
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b0, "R7");
      check("R7", lock_m, 2'b10);
   endtask

   task automatic t_random();
      for (int s = 0; s < 40; s++) begin
         do_reset();
         for (int i = 0; i < 30; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[3:1] != 3'b000, r[0], "R2");
         end
      end
   endtask

   initial begin
      do_reset();
      t_zero_pair();
      t_one_pair();
      t_alternate();
      t_idle_gap();
      t_lock_hold();
      t_mid_reset();
      t_random();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule